// File: doc/BRIEF.md
# Programmable I/O chip-select decoder

This block produces one active-low chip select for a peripheral that sits in a 16-bit I/O address space. A 16-bit configuration word holds an I/O base address in its upper fourteen bits and a two-bit range code in its lowest two bits. The range code sets the size of the decoded window: 4, 8 or 16 contiguous bytes. One code value switches the decoder off. Software writes and reads the word through a small register port that has a write enable and two byte enables.

On every clock the decoder looks at the address and type of the current I/O cycle. It drives the select low on the following clock when the strobe is high, the cycle is an I/O access, the address falls inside the programmed window and the initiator is not a master on the secondary bus. Memory cycles and secondary-bus masters never cause a select.

Top module: `iocs_decoder`

## Requirements
- R1: The configuration word is written on a clock edge where `cfg_we` is 1. `cfg_be[0]` enables bits 7:0 and `cfg_be[1]` enables bits 15:8. A byte whose enable is 0 keeps its old value. `cfg_rdata` always shows the current word.
- R2: After reset the configuration word is 0x0000, which means base 0 with a 4-byte window, and `sel_n` is 1.
- R3: With range code 00 (word bits 1:0), an I/O address selects when its bits 15:2 equal word bits 15:2. This is a 4-byte window.
- R4: With range code 01, address bit 2 is not compared. This gives an 8-byte window aligned to 8 bytes: base bits 15:3 against address bits 15:3.
- R5: With range code 11, address bits 3 and 2 are not compared. This gives a 16-byte window aligned to 16 bytes.
- R6: With range code 10 the decoder is off, and `sel_n` stays 1 for every address.
- R7: A cycle with `cyc_from_secondary` = 1 never drives `sel_n` low.
- R8: A cycle with `cyc_is_io` = 0 (a memory cycle) never drives `sel_n` low, whatever its address.
- R9: `sel_n` is registered. In the clock after an edge that samples a qualifying strobe, `sel_n` is 0. In the clock after an edge that samples the strobe low, `sel_n` is 1 again. A strobe that stays high keeps `sel_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_be | input | 2 | Byte enables for the configuration write |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Current configuration word |
| cyc_strobe | input | 1 | The current cycle carries a valid address |
| cyc_addr | input | 16 | Cycle address |
| cyc_is_io | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| cyc_from_secondary | input | 1 | 1 when a secondary-bus master started the cycle |
| sel_n | output | 1 | Active-low chip select, registered |

## Verification
The assertions assume that the cycle inputs are sampled only at the clock edge and are free of X after reset. They also assume that the configuration word seen by the decoder in a clock is the word that was registered at the edge before it. The bench changes every input on the falling edge, keeps all inputs at 0 while reset is held, and leaves at least one idle clock between a configuration write and the cycles that depend on it. Each registered sample is therefore well defined.

// File: rtl/iocs_pkg.sv
package iocs_pkg;
    localparam int ADDR_W    = 16;
    localparam int CODE_W    = 2;
    localparam int BASE_LSB  = CODE_W;

    typedef enum logic [CODE_W-1:0] {
        RNG_4B   = 2'b00,
        RNG_8B   = 2'b01,
        RNG_OFF  = 2'b10,
        RNG_16B  = 2'b11
    } range_code_e;

    typedef struct packed {
        logic [ADDR_W-1:0] word;
    } cfg_state_t;

    typedef struct packed {
        logic sel_n;
    } sel_state_t;
endpackage

// File: rtl/iocs_cfg_reg.sv
module iocs_cfg_reg
    import iocs_pkg::*;
#(
    parameter int WORD_W = ADDR_W,
    localparam int NBYTES = WORD_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [NBYTES-1:0] be,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] word_q
);
    logic [WORD_W-1:0] word_d;
    logic [WORD_W-1:0] word_r;

    always_comb begin
        word_d = word_r;
        for (int b = 0; b < NBYTES; b++) begin
            if (we && be[b]) begin
                word_d[b*8 +: 8] = wdata[b*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_r <= '0;
        end else begin
            word_r <= word_d;
        end
    end

    assign word_q = word_r;

    // R1: a byte whose enable is clear keeps its old value
    a_r1_upper_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!(we && be[NBYTES-1])) |=> $stable(word_q[WORD_W-1 -: 8]));
    a_r1_lower_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!(we && be[0])) |=> $stable(word_q[7:0]));
endmodule

// File: rtl/iocs_match.sv
module iocs_match
    import iocs_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CODE_W,
    localparam int LSB = CW
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] cfg_word,
    output logic          hit
);
    logic [AW-1:LSB] bit_ok;
    logic [CW-1:0]   code;
    logic            dec_off;

    assign code    = cfg_word[CW-1:0];
    assign dec_off = (code == RNG_OFF);

    genvar i;
    generate
        for (i = LSB; i < AW; i++) begin : g_cmp
            if (i < LSB + CW) begin : g_maskable
                // code bit (i-LSB) set means address bit i is ignored
                assign bit_ok[i] = code[i-LSB] | (addr[i] == cfg_word[i]);
            end else begin : g_fixed
                assign bit_ok[i] = (addr[i] == cfg_word[i]);
            end
        end
    endgenerate

    assign hit = !dec_off && (&bit_ok);
endmodule

// File: rtl/iocs_sel_out.sv
module iocs_sel_out
    import iocs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic is_io,
    input  logic from_secondary,
    input  logic hit,
    output logic sel_n
);
    sel_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.sel_n = !(strobe && is_io && !from_secondary && hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_n = st_q.sel_n;

    // R7: secondary-bus masters never select
    a_r7_no_secondary: assert property (@(posedge clk) disable iff (!rst_n)
        from_secondary |=> sel_n);
    // R8: memory cycles never select
    a_r8_no_memory: assert property (@(posedge clk) disable iff (!rst_n)
        !is_io |=> sel_n);
    // R9: select released the clock after the strobe drops
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> sel_n);
    // R9: select asserted only after a sampled strobe
    a_r9_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_n) |-> $past(strobe));
endmodule

// File: rtl/iocs_decoder.sv
module iocs_decoder
    import iocs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_be,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] cfg_rdata,
    input  logic        cyc_strobe,
    input  logic [15:0] cyc_addr,
    input  logic        cyc_is_io,
    input  logic        cyc_from_secondary,
    output logic        sel_n
);
    logic [ADDR_W-1:0] cfg_word;
    logic              hit;

    iocs_cfg_reg #(.WORD_W(ADDR_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .be     (cfg_be),
        .wdata  (cfg_wdata),
        .word_q (cfg_word)
    );

    iocs_match #(.AW(ADDR_W), .CW(CODE_W)) u_match (
        .addr     (cyc_addr),
        .cfg_word (cfg_word),
        .hit      (hit)
    );

    iocs_sel_out u_sel (
        .clk            (clk),
        .rst_n          (rst_n),
        .strobe         (cyc_strobe),
        .is_io          (cyc_is_io),
        .from_secondary (cyc_from_secondary),
        .hit            (hit),
        .sel_n          (sel_n)
    );

    assign cfg_rdata = cfg_word;

    // R6: a word holding the off code never leads to a select
    a_r6_off_code: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_word[CODE_W-1:0]) == RNG_OFF) |-> sel_n);
endmodule

// File: tb/iocs_decoder_tb_top.sv
`timescale 1ns/1ps
module iocs_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_be = 2'b00;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        cyc_strobe = 1'b0;
    logic [15:0] cyc_addr = '0;
    logic        cyc_is_io = 1'b0;
    logic        cyc_from_secondary = 1'b0;
    logic        sel_n;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R2";
    logic done = 1'b0;

    always #2 clk = ~clk;

    iocs_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cyc_strobe(cyc_strobe),
        .cyc_addr(cyc_addr), .cyc_is_io(cyc_is_io),
        .cyc_from_secondary(cyc_from_secondary), .sel_n(sel_n)
    );

    // behavioural reference model
    logic [15:0] m_word;
    logic        m_sel_n;

    function automatic bit in_window(int addr, int word);
        int code = word % 4;
        int size;
        if (code == 2) return 1'b0;
        size = (code == 0) ? 4 : (code == 1) ? 8 : 16;
        return (addr / size) == ((word - code) / size);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_word  <= 16'h0000;
            m_sel_n <= 1'b1;
        end else begin
            if (cfg_we && cfg_be[0]) m_word[7:0]  <= cfg_wdata[7:0];
            if (cfg_we && cfg_be[1]) m_word[15:8] <= cfg_wdata[15:8];
            m_sel_n <= !(cyc_strobe && cyc_is_io && !cyc_from_secondary &&
                         in_window(int'(cyc_addr), int'(m_word)));
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_cmp++;
            if (sel_n !== m_sel_n) begin
                n_bad++;
                $display("FAIL %s sel_n addr=%h actual=%b expected=%b", tag, cyc_addr, sel_n, m_sel_n);
            end
            n_cmp++;
            if (cfg_rdata !== m_word) begin
                n_bad++;
                $display("FAIL R1 cfg_rdata actual=%h expected=%h", cfg_rdata, m_word);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] be, logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_be = 2'b00;
        idle(1);
    endtask

    task automatic cyc(logic [15:0] a, logic io, logic sec, int len);
        @(negedge clk);
        cyc_strobe = 1'b1; cyc_addr = a; cyc_is_io = io; cyc_from_secondary = sec;
        repeat (len) @(negedge clk);
        cyc_strobe = 1'b0; cyc_is_io = 1'b0; cyc_from_secondary = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        tag = "R2";
        idle(3);
        rst_n = 1'b1;
        idle(1);
        cyc(16'h0000, 1'b1, 1'b0, 1);   // R2: default word decodes 0..3
        cyc(16'h0004, 1'b1, 1'b0, 1);

        tag = "R1";
        wr(2'b11, 16'h1234);
        wr(2'b01, 16'hFF40);            // R1: only the low byte changes
        wr(2'b10, 16'h0377);            // R1: only the high byte changes
        wr(2'b00, 16'hFFFF);            // R1: nothing changes

        tag = "R3";
        wr(2'b11, 16'h0340);
        cyc(16'h033F, 1'b1, 1'b0, 1);
        cyc(16'h0340, 1'b1, 1'b0, 1);
        cyc(16'h0343, 1'b1, 1'b0, 1);
        cyc(16'h0344, 1'b1, 1'b0, 1);
        wr(2'b11, 16'hFFFC);
        cyc(16'hFFFB, 1'b1, 1'b0, 1);
        cyc(16'hFFFF, 1'b1, 1'b0, 1);

        tag = "R4";
        wr(2'b11, 16'h0349);
        cyc(16'h0347, 1'b1, 1'b0, 1);
        cyc(16'h0348, 1'b1, 1'b0, 1);
        cyc(16'h034F, 1'b1, 1'b0, 1);
        cyc(16'h0350, 1'b1, 1'b0, 1);

        tag = "R5";
        wr(2'b11, 16'h0357);
        cyc(16'h034F, 1'b1, 1'b0, 1);
        cyc(16'h0350, 1'b1, 1'b0, 1);
        cyc(16'h035F, 1'b1, 1'b0, 1);
        cyc(16'h0360, 1'b1, 1'b0, 1);

        tag = "R9";
        cyc(16'h0355, 1'b1, 1'b0, 5);   // held strobe keeps select low

        tag = "R7";
        cyc(16'h0352, 1'b1, 1'b1, 2);
        tag = "R8";
        cyc(16'h0352, 1'b0, 1'b0, 2);

        tag = "R6";
        wr(2'b11, 16'h0342);
        for (int a = 16'h0338; a < 16'h0350; a++) cyc(16'(a), 1'b1, 1'b0, 1);

        idle(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        done = 1'b1;
        n_cmp++;
        n_bad++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule